// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block moves 32-bit words from a transmit queue onto an SPI bus and gathers the returned bytes into a receive queue. Software sets a burst length in bits. A burst can be shorter than one word, so only the low bytes of the word are shifted. It can also span several words. Each word is shifted low byte first, and each byte is sent most significant bit first in SPI mode 0. The serial clock is a fixed division of the system clock. Each returned byte goes into the same byte lane of a receive word, and lanes that carried no byte read as zero.

A drain can start in two ways. In immediate mode, it starts as soon as a word is queued, or when immediate mode is switched on while words are already waiting. In the other mode, it starts when software raises the exchange request. A drain stops at the end of a burst, unless multi-burst mode holds it open until the transmit queue is empty. Two sticky flags report transfer completion and a dropped receive word. Four active-low chip selects drive the selected master channel low. Dropping the enable input clears the whole engine.

Top module: `spi_burst_engine`

## Requirements
- R1: While `cfg_en` is low, or one cycle after `rst`, both queues are empty, `tc_flag`, `ro_flag` and `xch_busy` are 0, `spi_sclk` is 0 and all `spi_cs_n` bits are 1.
- R2: The burst length in bits is `cfg_burst_len` + 1. A word carries min(remaining, 32) bits of it, rounded up to whole bytes. After each byte the remaining count drops by 8, and a new burst is loaded only when the count is zero or below.
- R3: The bytes of a word leave low byte (bits 7:0) first. Within a byte the most significant bit goes first. `spi_sclk` idles low, `spi_mosi` changes on falling edges and `spi_miso` is sampled on rising edges.
- R4: The byte received while byte k of a word is sent lands in bits 8k+7:8k of the receive word. Lanes with no byte sent are zero.
- R5: With `cfg_start_on_write` = 1 and the selected channel a master, an accepted write to the transmit queue starts a drain.
- R6: A pulse on `xch_req` sets `xch_busy`. When `xch_busy` was 0, `cfg_start_on_write` = 0 and the channel is a master, the pulse also starts a drain. Words queued with `cfg_start_on_write` = 0 and no request are not sent. A drain that ends with the transmit queue empty sets `tc_flag` and clears `xch_busy`.
- R7: A rise of `cfg_start_on_write` while the transmit queue is not empty starts a drain.
- R8: Without multi-burst mode, the end of a burst sets `tc_flag` and stops the drain, even if words remain.
- R9: Multi-burst mode needs three conditions: the channel is a master, `cfg_start_on_write` = 0, and the channel's bit in `cfg_chan_multi` is set. In this mode bursts follow one another until the transmit queue is empty, and `tc_flag` rises only then.
- R10: A completed word that finds the receive queue full is dropped and sets `ro_flag`.
- R11: If the channel chosen by `cfg_chan_sel` has its `cfg_chan_master` bit set, only that `spi_cs_n` bit is 0, one cycle after the configuration is applied. Otherwise all bits are 1.
- R12: `tc_clr` clears `tc_flag` and `ro_clr` clears `ro_flag`.
- R13: Writes to the transmit queue while it is full or while `cfg_en` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Engine enable; low clears everything |
| cfg_start_on_write | input | 1 | Immediate start mode |
| cfg_burst_len | input | 12 | Burst length in bits minus one |
| cfg_chan_sel | input | 2 | Selected chip-select channel |
| cfg_chan_master | input | 4 | Per-channel master mode |
| cfg_chan_multi | input | 4 | Per-channel multi-burst chip-select mode |
| xch_req | input | 1 | Exchange request pulse |
| xch_busy | output | 1 | Exchange bit |
| tx_wr | input | 1 | Transmit queue write strobe |
| tx_data | input | 32 | Transmit word |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_rd | input | 1 | Receive queue pop strobe |
| rx_data | output | 32 | Head of receive queue, zero when empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tc_flag | output | 1 | Transfer complete, sticky |
| tc_clr | input | 1 | Clear `tc_flag` |
| ro_flag | output | 1 | Receive overflow, sticky |
| ro_clr | input | 1 | Clear `ro_flag` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
A wrong remaining-bit count shows within one burst: the number of bytes seen on `spi_mosi` changes, and the zeroed lanes of the receive word move. `tc_flag` also rises after the wrong word. A stuck start-pending state or a lost exchange bit shows as a drain that never starts, which the bench's completion timeout reports. A wrong byte lane or bit order corrupts the first received word. Chip-select errors are caught on the next clock, because the bench compares them every cycle.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int CS_NUM   = 4;
    localparam int CS_SEL_W = $clog2(CS_NUM);
    localparam int BURST_W  = 12;
    localparam int REM_W    = BURST_W + 2;

    typedef logic signed [REM_W-1:0] bit_count_t;

    localparam bit_count_t WORD_BITS = bit_count_t'(WORD_W);
    localparam bit_count_t BYTE_BITS = bit_count_t'(BYTE_W);
    localparam bit_count_t NO_BITS   = '0;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_SHIFT,
        SEQ_STORE
    } seq_state_e;

    typedef struct packed {
        logic                start_on_write;
        logic [BURST_W-1:0]  burst_len;
        logic [CS_SEL_W-1:0] sel;
        logic [CS_NUM-1:0]   master;
        logic [CS_NUM-1:0]   multi;
    } spi_cfg_t;

    function automatic logic chan_is_master(spi_cfg_t c);
        return c.master[c.sel];
    endfunction

    function automatic logic multi_burst_on(spi_cfg_t c);
        return c.master[c.sel] && !c.start_on_write && c.multi[c.sel];
    endfunction

    function automatic bit_count_t burst_bits(spi_cfg_t c);
        return bit_count_t'({2'b00, c.burst_len}) + bit_count_t'(1);
    endfunction

endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_burst_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(BYTE_W);

    logic              active;
    logic [DIV_W-1:0]  div_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic              sclk_q, done_q;

    assign done    = done_q;
    assign rx_byte = rx_sh;
    assign sclk    = sclk_q;
    assign mosi    = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                tx_sh   <= tx_byte;
                div_cnt <= '0;
                bit_cnt <= '0;
                sclk_q  <= 1'b0;
            end else if (active) begin
                if (div_cnt == DIV_W'(HALF_DIV-1)) begin
                    div_cnt <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_sh  <= {rx_sh[BYTE_W-2:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_cnt == BIT_W'(BYTE_W-1)) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
    import spi_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_cfg_t          cfg,
    input  logic              tx_accept,
    input  logic              xch_req,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_head,
    input  logic              rx_full,
    input  logic              sh_done,
    input  logic [BYTE_W-1:0] sh_rx_byte,
    input  logic              tc_clr,
    input  logic              ro_clr,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              sh_start,
    output logic [BYTE_W-1:0] sh_tx_byte,
    output logic              xch_busy,
    output logic              tc_flag,
    output logic              ro_flag
);
    localparam int LANE_W = $clog2(WORD_W / BYTE_W);

    seq_state_e        st;
    logic              pend, smc_q, xch_q, tc_q, ro_q, start_q;
    bit_count_t        remain, wbits, rem_load, wbits_load;
    logic [WORD_W-1:0] word_sh, acc;
    logic [LANE_W-1:0] lane;
    logic [BYTE_W-1:0] byte_q;
    logic              master, multi, trig;

    assign master = chan_is_master(cfg);
    assign multi  = multi_burst_on(cfg);

    // start conditions: write in immediate mode, rising exchange request
    // outside immediate mode, or immediate mode switched on with data queued
    assign trig = master && (
                    (tx_accept && cfg.start_on_write) ||
                    (xch_req && !xch_q && !cfg.start_on_write) ||
                    (cfg.start_on_write && !smc_q && !tx_empty));

    assign rem_load   = (remain <= NO_BITS) ? burst_bits(cfg) : remain;
    assign wbits_load = (rem_load > WORD_BITS) ? WORD_BITS : rem_load;

    assign tx_pop     = (st == SEQ_LOAD);
    assign rx_push    = (st == SEQ_STORE) && !rx_full;
    assign rx_word    = acc;
    assign sh_start   = start_q;
    assign sh_tx_byte = byte_q;
    assign xch_busy   = xch_q;
    assign tc_flag    = tc_q;
    assign ro_flag    = ro_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SEQ_IDLE;
            pend    <= 1'b0;
            smc_q   <= 1'b0;
            xch_q   <= 1'b0;
            tc_q    <= 1'b0;
            ro_q    <= 1'b0;
            start_q <= 1'b0;
            remain  <= NO_BITS;
            wbits   <= NO_BITS;
            word_sh <= '0;
            acc     <= '0;
            lane    <= '0;
            byte_q  <= '0;
        end else begin
            start_q <= 1'b0;
            smc_q   <= cfg.start_on_write;
            if (tc_clr)  tc_q  <= 1'b0;
            if (ro_clr)  ro_q  <= 1'b0;
            if (xch_req) xch_q <= 1'b1;
            if (trig)    pend  <= 1'b1;

            unique case (st)
                SEQ_IDLE: begin
                    if (pend) begin
                        pend <= trig;
                        if (tx_empty) begin
                            tc_q  <= 1'b1;
                            xch_q <= 1'b0;
                        end else begin
                            st <= SEQ_LOAD;
                        end
                    end
                end
                SEQ_LOAD: begin
                    if (remain <= NO_BITS && multi) xch_q <= 1'b1;
                    remain  <= rem_load;
                    wbits   <= wbits_load;
                    word_sh <= tx_head;
                    acc     <= '0;
                    lane    <= '0;
                    byte_q  <= tx_head[BYTE_W-1:0];
                    start_q <= 1'b1;
                    st      <= SEQ_SHIFT;
                end
                SEQ_SHIFT: begin
                    if (sh_done) begin
                        acc[{lane, 3'b000} +: BYTE_W] <= sh_rx_byte;
                        remain <= remain - BYTE_BITS;
                        wbits  <= wbits - BYTE_BITS;
                        lane   <= lane + 1'b1;
                        if (wbits > BYTE_BITS) begin
                            byte_q  <= word_sh[2*BYTE_W-1:BYTE_W];
                            word_sh <= word_sh >> BYTE_W;
                            start_q <= 1'b1;
                        end else begin
                            st <= SEQ_STORE;
                        end
                    end
                end
                SEQ_STORE: begin
                    if (rx_full) ro_q <= 1'b1;
                    if (remain <= NO_BITS && !multi) begin
                        tc_q <= 1'b1;
                        if (tx_empty) xch_q <= 1'b0;
                        st <= SEQ_IDLE;
                    end else if (tx_empty) begin
                        tc_q  <= 1'b1;
                        xch_q <= 1'b0;
                        st    <= SEQ_IDLE;
                    end else begin
                        st <= SEQ_LOAD;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int HALF_DIV   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_start_on_write,
    input  logic [BURST_W-1:0]  cfg_burst_len,
    input  logic [CS_SEL_W-1:0] cfg_chan_sel,
    input  logic [CS_NUM-1:0]   cfg_chan_master,
    input  logic [CS_NUM-1:0]   cfg_chan_multi,
    input  logic                xch_req,
    output logic                xch_busy,
    input  logic                tx_wr,
    input  logic [WORD_W-1:0]   tx_data,
    output logic                tx_full,
    output logic                tx_empty,
    input  logic                rx_rd,
    output logic [WORD_W-1:0]   rx_data,
    output logic                rx_full,
    output logic                rx_empty,
    output logic                tc_flag,
    input  logic                tc_clr,
    output logic                ro_flag,
    input  logic                ro_clr,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [CS_NUM-1:0]   spi_cs_n
);
    spi_cfg_t          cfg;
    logic              eng_rst, tx_accept, tx_pop, rx_push;
    logic [WORD_W-1:0] tx_head, rx_word, rx_head;
    logic              sh_start, sh_done;
    logic [BYTE_W-1:0] sh_tx_byte, sh_rx_byte;
    logic [CS_NUM-1:0] cs_q;

    assign cfg = '{start_on_write: cfg_start_on_write,
                   burst_len:      cfg_burst_len,
                   sel:            cfg_chan_sel,
                   master:         cfg_chan_master,
                   multi:          cfg_chan_multi};

    assign eng_rst   = rst || !cfg_en;
    assign tx_accept = tx_wr && cfg_en && !tx_full;
    assign rx_data   = rx_empty ? '0 : rx_head;
    assign spi_cs_n  = cs_q;

    spi_sync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst(eng_rst), .push(tx_accept), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

    spi_sync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst(eng_rst), .push(rx_push), .wdata(rx_word),
        .pop(rx_rd), .rdata(rx_head), .full(rx_full), .empty(rx_empty));

    spi_byte_shifter #(.HALF_DIV(HALF_DIV)) shifter_i (
        .clk(clk), .rst(eng_rst), .start(sh_start), .tx_byte(sh_tx_byte),
        .miso(spi_miso), .done(sh_done), .rx_byte(sh_rx_byte),
        .sclk(spi_sclk), .mosi(spi_mosi));

    spi_burst_seq seq_i (
        .clk(clk), .rst(eng_rst), .cfg(cfg), .tx_accept(tx_accept),
        .xch_req(xch_req), .tx_empty(tx_empty), .tx_head(tx_head),
        .rx_full(rx_full), .sh_done(sh_done), .sh_rx_byte(sh_rx_byte),
        .tc_clr(tc_clr), .ro_clr(ro_clr), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .sh_start(sh_start),
        .sh_tx_byte(sh_tx_byte), .xch_busy(xch_busy), .tc_flag(tc_flag),
        .ro_flag(ro_flag));

    for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
        always_ff @(posedge clk) begin
            if (eng_rst) cs_q[i] <= 1'b1;
            else         cs_q[i] <= !(chan_is_master(cfg) && (cfg.sel == CS_SEL_W'(i)));
        end
    end
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk
    import spi_burst_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_en,
    input logic [CS_NUM-1:0] spi_cs_n,
    input logic              spi_sclk,
    input logic              tx_empty,
    input logic              rx_empty,
    input logic              rx_full,
    input logic              tc_flag,
    input logic              ro_flag,
    input logic              xch_busy
);
    // R11
    cs_single_low_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));

    // R1
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (tx_empty && rx_empty && !tc_flag && !ro_flag &&
                     !xch_busy && !spi_sclk && (&spi_cs_n)));

    // R10
    overflow_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ro_flag) |-> $past(rx_full));

    // R6
    xch_drop_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(xch_busy) && $past(cfg_en)) |-> $past(tx_empty));

    // R9
    tc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_flag) |-> $past(cfg_en));
endmodule

bind spi_burst_engine spi_burst_engine_chk chk_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .tx_empty(tx_empty), .rx_empty(rx_empty),
    .rx_full(rx_full), .tc_flag(tc_flag), .ro_flag(ro_flag),
    .xch_busy(xch_busy));

// File: tb/spi_burst_engine_tb_top.sv
`timescale 1ns/1ps
module spi_burst_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 0, cfg_start_on_write = 0;
    logic [11:0] cfg_burst_len = 0;
    logic [1:0]  cfg_chan_sel = 0;
    logic [3:0]  cfg_chan_master = 0, cfg_chan_multi = 0;
    logic        xch_req = 0, xch_busy;
    logic        tx_wr = 0, tx_full, tx_empty;
    logic [31:0] tx_data = 0, rx_data;
    logic        rx_rd = 0, rx_full, rx_empty;
    logic        tc_flag, tc_clr = 0, ro_flag, ro_clr = 0;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;

    always #2.5 clk = ~clk;
    assign spi_miso = ~spi_mosi;  // slave answers with the inverted bit

    spi_burst_engine dut_i (.*);

    int errs = 0, checks = 0;
    bit started = 0;
    logic [3:0] cs_exp = 4'hF;
    logic [7:0] bitbuf = 0;
    int nbits = 0;
    logic [7:0] mosi_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference for chip selects, compared every clock (R11)
    always @(posedge clk)
        cs_exp <= (rst || !cfg_en || !cfg_chan_master[cfg_chan_sel]) ? 4'hF
                  : ~(4'b0001 << cfg_chan_sel);
    always @(negedge clk)
        if (started) chk(spi_cs_n == cs_exp, "R11", "cs_n", {28'd0, spi_cs_n}, {28'd0, cs_exp});

    // MOSI byte capture on rising serial clock, MSB first (R3)
    always @(posedge spi_sclk) begin
        bitbuf = {bitbuf[6:0], spi_mosi};
        nbits++;
        if (nbits == 8) begin
            mosi_q.push_back(bitbuf);
            nbits = 0;
        end
    end

    function automatic logic [31:0] exp_rx(input logic [31:0] w, input int nbytes);
        logic [31:0] r = 0;
        for (int k = 0; k < nbytes; k++) r[k*8 +: 8] = ~w[k*8 +: 8];
        return r;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_tx(input logic [31:0] w);
        tx_data = w; tx_wr = 1; @(negedge clk); tx_wr = 0;
    endtask

    task automatic pulse_xch();
        xch_req = 1; @(negedge clk); xch_req = 0;
    endtask

    task automatic wait_tc(input string req);
        int n = 0;
        while (!tc_flag && n < 20000) begin @(negedge clk); n++; end
        chk(tc_flag, req, "tc_flag timeout", {31'd0, tc_flag}, 32'd1);
        @(negedge clk);
    endtask

    task automatic clear_tc();
        tc_clr = 1; @(negedge clk); tc_clr = 0;
        chk(!tc_flag, "R12", "tc after clear", {31'd0, tc_flag}, 32'd0);
    endtask

    task automatic read_chk(input logic [31:0] exp, input string req);
        chk(rx_data == exp, req, "rx word", rx_data, exp);
        rx_rd = 1; @(negedge clk); rx_rd = 0;
    endtask

    task automatic mosi_chk(input logic [31:0] w, input int nbytes, input string req);
        chk(mosi_q.size() == nbytes, req, "mosi byte count", mosi_q.size(), nbytes);
        for (int k = 0; k < nbytes && mosi_q.size() > 0; k++) begin
            logic [7:0] b = mosi_q.pop_front();
            chk(b == w[k*8 +: 8], req, "mosi byte", {24'd0, b}, {24'd0, w[k*8 +: 8]});
        end
        mosi_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        cyc(5); rst = 0; started = 1; cyc(1);
        // R1 reset state
        chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1", "queues empty", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
        chk(!tc_flag && !ro_flag && !xch_busy, "R1", "flags", {tc_flag, ro_flag, xch_busy}, 0);
        chk(spi_cs_n == 4'hF && !spi_sclk, "R1", "cs/sclk", {spi_cs_n, spi_sclk}, 5'h1E);

        // R5 R3 R4 R11: immediate mode, 32-bit burst on channel 1
        cfg_en = 1; cfg_chan_master = 4'b0010; cfg_chan_sel = 1;
        cfg_start_on_write = 1; cfg_burst_len = 31; cyc(3);
        chk(spi_cs_n == 4'b1101, "R11", "selected low", {28'd0, spi_cs_n}, 32'hD);
        write_tx(32'hA5C30F81);
        wait_tc("R5");
        mosi_chk(32'hA5C30F81, 4, "R3");
        read_chk(exp_rx(32'hA5C30F81, 4), "R4");
        clear_tc();

        // R2 R4: 12-bit burst sends two bytes, upper lanes zero
        cfg_burst_len = 11;
        write_tx(32'h12345678);
        wait_tc("R2");
        mosi_chk(32'h12345678, 2, "R2");
        read_chk(32'h0000A987, "R4");
        clear_tc();

        // R6 R8 R7: exchange start, burst end stops, immediate-mode rise resumes
        cfg_start_on_write = 0; cfg_burst_len = 31; cyc(2);
        write_tx(32'h01020304); write_tx(32'h05060708); write_tx(32'h090A0B0C);
        cyc(20);
        chk(mosi_q.size() == 0 && !tx_empty, "R6", "no start without request", mosi_q.size(), 0);
        pulse_xch();
        chk(xch_busy, "R6", "xch set", {31'd0, xch_busy}, 1);
        wait_tc("R6");
        mosi_chk(32'h01020304, 4, "R8");
        chk(!tx_empty && xch_busy, "R8", "stopped with words left", {tx_empty, xch_busy}, 2'b01);
        clear_tc();
        cfg_start_on_write = 1;
        wait_tc("R7");
        mosi_chk(32'h05060708, 4, "R7");
        chk(xch_busy, "R7", "xch still set", {31'd0, xch_busy}, 1);
        clear_tc();
        cfg_start_on_write = 0; cyc(3); cfg_start_on_write = 1;
        wait_tc("R7");
        mosi_chk(32'h090A0B0C, 4, "R7");
        chk(tx_empty && !xch_busy, "R6", "xch cleared at empty", {tx_empty, xch_busy}, 2'b10);
        clear_tc();
        read_chk(exp_rx(32'h01020304, 4), "R8");
        read_chk(exp_rx(32'h05060708, 4), "R7");
        read_chk(exp_rx(32'h090A0B0C, 4), "R7");

        // R9: multi-burst, 64-bit bursts run across three words
        cfg_start_on_write = 0; cfg_chan_multi = 4'b0010; cfg_burst_len = 63; cyc(2);
        write_tx(32'h11223344); write_tx(32'h55667788); write_tx(32'h99AABBCC);
        pulse_xch();
        wait_tc("R9");
        chk(mosi_q.size() == 12, "R9", "tc only after all words", mosi_q.size(), 12);
        mosi_q.delete();
        chk(tx_empty && !xch_busy, "R9", "drained", {tx_empty, xch_busy}, 2'b10);
        read_chk(exp_rx(32'h11223344, 4), "R9");
        read_chk(exp_rx(32'h55667788, 4), "R9");
        read_chk(exp_rx(32'h99AABBCC, 4), "R9");

        // R1 R13: disable clears; writes while disabled ignored
        cfg_en = 0; cyc(1);
        chk(!tc_flag && tx_empty && spi_cs_n == 4'hF, "R1", "disabled state", {tc_flag, tx_empty, spi_cs_n}, 6'h1F);
        write_tx(32'hDEAD0001); cfg_en = 1; cyc(2);
        chk(tx_empty, "R13", "write while disabled", {31'd0, tx_empty}, 1);
        cfg_chan_master = 4'b0000; cyc(2);
        chk(spi_cs_n == 4'hF, "R11", "no master all high", {28'd0, spi_cs_n}, 32'hF);
        cfg_chan_master = 4'b0010;

        // R13: 65 writes, only 64 kept; drained in 8-bit multi bursts
        cfg_burst_len = 7;
        for (int i = 0; i < 65; i++) write_tx(i);
        chk(tx_full, "R13", "tx full", {31'd0, tx_full}, 1);
        pulse_xch();
        wait_tc("R13");
        chk(tx_empty && rx_full && !ro_flag, "R13", "64 words moved", {tx_empty, rx_full, ro_flag}, 3'b110);
        mosi_q.delete();
        clear_tc();

        // R10: one more word with receive queue full is dropped
        cfg_start_on_write = 1;
        write_tx(32'h000000AB);
        wait_tc("R10");
        chk(ro_flag && rx_full, "R10", "overflow flag", {ro_flag, rx_full}, 2'b11);
        for (int i = 0; i < 64; i++) read_chk(32'hFF - i, "R10");
        chk(rx_empty, "R10", "dropped word absent", {31'd0, rx_empty}, 1);
        ro_clr = 1; cyc(1); ro_clr = 0;
        chk(!ro_flag, "R12", "ro after clear", {31'd0, ro_flag}, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule